// File: doc/BRIEF.md
# I2C Target with Strap-Selected Address

This block is the target side of an I2C link inside a larger chip. It samples the SCL and SDA lines with the system clock and looks for start and stop conditions. It shifts in the address byte and any data bytes that follow, and it answers a read by putting bytes onto the shared data line. Inside the chip it connects to a simple register file through an address, a write-data bus, a write strobe and a read-data bus.

The block answers to two 7-bit addresses:

- **Device address.** Its upper five bits are fixed at `10011`. Its two low bits come from a 2-bit strap input, so the address is one of 0x4C to 0x4F.
- **Broadcast address, 0x48.** This address accepts writes only, so a single transfer can set up several devices at once.

An output flag shows which of the two addresses opened the current transfer.

An 8-bit register pointer controls register access:

- The first data byte of a write loads the pointer.
- Each later write byte goes to the location the pointer names, and the pointer then advances by one.
- A read returns the byte at the pointer and advances it in the same way.
- A repeated start begins a new address phase but keeps the pointer. A master can therefore set the pointer in a write and then read from that location without sending a stop in between.
- SDA is never driven high. The block can only pull it low, through an output-enable signal.

Top module: `i2c_strap_target`

## Requirements
- R1: A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. After a stop, `addressed_o` and `sda_oe_o` are both 0. While an accepted transfer is in progress, `addressed_o` is 1.
- R2: After a start, the first byte is read MSB first. Its upper seven bits are the address and bit 0 is the direction, with 1 meaning read. The address `{5'b10011, strap_i}` is acknowledged for both reads and writes. With strap 00 the address byte is 0x98 for a write and 0x99 for a read. With strap 01 it is 0x9A or 0x9B, and with strap 11 it is 0x9E.
- R3: A write to 0x48 (address byte 0x90) is acknowledged whatever the strap value is. `hit_bcast_o` is 1 during a transfer opened by the broadcast address and 0 during a transfer opened by the device address.
- R4: A read to 0x48 (address byte 0x91) is not acknowledged, and neither is any address that matches nothing. After such a byte the block does not pull SDA low and issues no register write until the next start.
- R5: In a write, the first data byte loads the pointer. Each later byte produces a one-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then increments, wrapping from 0xFF to 0x00.
- R6: Each byte the block accepts is acknowledged by holding SDA low for the ninth SCL clock.
- R7: In a read, the block sends the byte at the pointer MSB first and then increments the pointer. If the master acknowledges in the ninth clock, the block sends the next byte.
- R8: When the master does not acknowledge a read byte, the read ends and the block leaves SDA released until the next start.
- R9: A repeated start begins a new address phase and keeps the register pointer.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases the line |
| addressed_o | output | 1 | An accepted transfer is in progress |
| hit_bcast_o | output | 1 | The current transfer was opened by the broadcast address |
| reg_addr_o | output | 8 | Register-file address: the pointer, or the write address during a strobe |
| reg_wdata_o | output | 8 | Register-file write data |
| reg_we_o | output | 1 | One-cycle register-file write strobe |
| reg_rdata_i | input | 8 | Register-file read data for `reg_addr_o` |

## Verification
The assertions check the following on every cycle:

- The data-line enable changes only while the synchronised SCL is low.
- A stop releases the line and clears the addressed flag.
- Every write strobe lasts one cycle, and the pointer is one higher in the cycle after it.
- No strobe or broadcast flag appears outside an accepted transfer.

Other behaviour can only be shown by the bench scenarios, which drive whole bus transactions:

- which address bytes are acknowledged under each strap value;
- that broadcast reads are refused;
- the bytes returned by a read;
- that the pointer survives a repeated start;
- that the pointer wraps at 0xFF;
- that the line stays silent after a master NACK.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] BYTE_BITS = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2ct_linecond.sv
module i2ct_linecond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2ct_pkg::*;
#(
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_PREFIX  = 5'b10011,
    parameter logic [6:0] BCAST_ADDR  = 7'h48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       strap_i,
    output logic             sda_oe_o,
    output logic             addressed_o,
    output logic             hit_bcast_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic [7:0]       reg_wdata_o,
    output logic             reg_we_o,
    input  logic [7:0]       reg_rdata_i
);
    typedef struct packed {
        tgt_state_e           state;
        logic [BYTE_W-1:0]    shift;
        logic [BIT_CNT_W-1:0] cnt;
        logic [PTR_W-1:0]     ptr;
        logic [PTR_W-1:0]     waddr;
        logic [BYTE_W-1:0]    wdata;
        logic                 we;
        logic                 oe;
        logic                 first;
        logic                 rw;
        logic                 nack;
        logic                 active;
        logic                 bcast;
    } tgt_regs_t;

    localparam tgt_regs_t REGS_RST = '{
        state: ST_IDLE, shift: '0, cnt: '0, ptr: '0, waddr: '0, wdata: '0,
        we: 1'b0, oe: 1'b0, first: 1'b0, rw: 1'b0, nack: 1'b0,
        active: 1'b0, bcast: 1'b0
    };

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic hit_dev, hit_bc;
    tgt_regs_t r_q, r_d;

    i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
    );
    i2ct_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
    );

    i2ct_linecond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign hit_dev = (r_q.shift[7:1] == {DEV_PREFIX, strap_i});
    assign hit_bc  = (r_q.shift[7:1] == BCAST_ADDR);

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (stop_det) begin
            r_d.state  = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.active = 1'b0;
            r_d.bcast  = 1'b0;
        end else if (start_det) begin
            r_d.state  = ST_ADDR;
            r_d.cnt    = '0;
            r_d.oe     = 1'b0;
            r_d.active = 1'b0;
            r_d.bcast  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shift = {r_q.shift[6:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == BYTE_BITS) begin
                        r_d.rw = r_q.shift[0];
                        if (hit_dev || (hit_bc && !r_q.shift[0])) begin
                            r_d.state  = ST_ADDR_ACK;
                            r_d.oe     = 1'b1;
                            r_d.active = 1'b1;
                            r_d.bcast  = hit_bc;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.state = ST_RD;
                            r_d.shift = reg_rdata_i;
                            r_d.oe    = ~reg_rdata_i[7];
                        end else begin
                            r_d.state = ST_WR;
                            r_d.first = 1'b1;
                            r_d.oe    = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        r_d.shift = {r_q.shift[6:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == BYTE_BITS) begin
                        r_d.state = ST_WR_ACK;
                        r_d.oe    = 1'b1;
                        if (r_q.first) begin
                            r_d.ptr   = PTR_W'(r_q.shift);
                            r_d.first = 1'b0;
                        end else begin
                            r_d.we    = 1'b1;
                            r_d.waddr = r_q.ptr;
                            r_d.wdata = r_q.shift;
                            r_d.ptr   = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        r_d.state = ST_WR;
                        r_d.cnt   = '0;
                        r_d.oe    = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == BYTE_BITS) begin
                            r_d.state = ST_RD_ACK;
                            r_d.oe    = 1'b0;
                            r_d.ptr   = r_q.ptr + 1'b1;
                        end else begin
                            r_d.shift = {r_q.shift[6:0], 1'b0};
                            r_d.oe    = ~r_q.shift[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_s;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.nack) begin
                            r_d.state  = ST_IDLE;
                            r_d.active = 1'b0;
                        end else begin
                            r_d.state = ST_RD;
                            r_d.shift = reg_rdata_i;
                            r_d.oe    = ~reg_rdata_i[7];
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign sda_oe_o    = r_q.oe;
    assign addressed_o = r_q.active;
    assign hit_bcast_o = r_q.bcast;
    assign reg_we_o    = r_q.we;
    assign reg_wdata_o = r_q.wdata;
    assign reg_addr_o  = r_q.we ? r_q.waddr : r_q.ptr;

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input logic             sda_oe_o,
    input logic             addressed_o,
    input logic             hit_bcast_o,
    input logic             reg_we_o,
    input logic [PTR_W-1:0] reg_addr_o
);
    // R10: the line enable only moves while synchronised SCL is low
    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_s));

    // R1: a stop releases the line and ends the transfer
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && !addressed_o));

    // R4: register writes only happen inside an accepted transfer
    a_r4_we_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> addressed_o);

    // R5: the write strobe lasts exactly one cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R5: the pointer advances by one after every write
    a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> (reg_addr_o == PTR_W'($past(reg_addr_o) + 1'b1)));

    // R3: the broadcast flag is only raised within an accepted transfer
    a_r3_bcast_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        hit_bcast_o |-> addressed_o);
endmodule

bind i2c_strap_target i2ct_checker #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .sda_oe_o   (sda_oe_o),
    .addressed_o(addressed_o),
    .hit_bcast_o(hit_bcast_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/tb_i2c_strap_target.sv
`timescale 1ns/1ps
module tb_i2c_strap_target;
    localparam time Q = 40ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_oe_o, addressed_o, hit_bcast_o, reg_we_o;
    logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
    logic       sda_line;

    logic [7:0] mem [256];
    int unsigned oe_cnt = 0, we_cnt = 0, bad_edges = 0;
    logic oe_prev = 1'b0;
    int unsigned checks = 0, fails = 0;

    always #2.5ns clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe_o;
    assign reg_rdata_i = mem[reg_addr_o];

    i2c_strap_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe_o),
        .addressed_o(addressed_o),
        .hit_bcast_o(hit_bcast_o),
        .reg_addr_o (reg_addr_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_we_o   (reg_we_o),
        .reg_rdata_i(reg_rdata_i)
    );

    always @(posedge clk) begin
        if (sda_oe_o) oe_cnt <= oe_cnt + 1;
        if (reg_we_o) begin
            mem[reg_addr_o] <= reg_wdata_o;
            we_cnt <= we_cnt + 1;
        end
        if (rst_n && sda_oe_o != oe_prev && scl_m) bad_edges <= bad_edges + 1;
        oe_prev <= sda_oe_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        #Q; sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        #Q; sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            #Q; sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0;
        end
        #Q; sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; ack = ~sda_line; #Q; scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            #Q; sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b[i] = sda_line; #Q; scl_m = 1'b0;
        end
        #Q; sda_m = ~give_ack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset oe", sda_oe_o, 0);
        chk("R1 reset addressed", addressed_o, 0);
        chk("R5 reset we", reg_we_o, 0);
        chk("R3 reset bcast", hit_bcast_o, 0);
    endtask

    task automatic t_write_dev();
        logic a;
        strap = 2'b00;
        bus_start();
        send_byte(8'h98, a); chk("R2 ack 0x98", a, 1);
        chk("R3 dev hit not bcast", hit_bcast_o, 0);
        send_byte(8'h10, a); chk("R6 ptr byte ack", a, 1);
        send_byte(8'hA1, a); chk("R6 data ack", a, 1);
        send_byte(8'hB2, a); chk("R6 data ack 2", a, 1);
        chk("R1 addressed in xfer", addressed_o, 1);
        bus_stop();
        chk("R1 addressed after stop", addressed_o, 0);
        chk("R5 mem 0x10", mem[8'h10], 8'hA1);
        chk("R5 mem 0x11", mem[8'h11], 8'hB2);
    endtask

    task automatic t_read();
        logic a; logic [7:0] d; int unsigned base;
        strap = 2'b01;
        bus_start();
        send_byte(8'h9A, a); chk("R2 ack 0x9A", a, 1);
        send_byte(8'h10, a);
        bus_start();
        send_byte(8'h9B, a); chk("R2 ack 0x9B read", a, 1);
        recv_byte(1'b1, d); chk("R7 first read byte", d, 8'hA1);
        recv_byte(1'b0, d); chk("R7 second read byte", d, 8'hB2);
        base = oe_cnt;
        recv_byte(1'b0, d);
        chk("R8 line idle after nack", d, 8'hFF);
        chk("R8 no drive after nack", oe_cnt - base, 0);
        bus_stop();
    endtask

    task automatic t_rs_ptr();
        logic a; logic [7:0] d;
        strap = 2'b01;
        bus_start();
        send_byte(8'h9A, a); send_byte(8'h30, a);
        send_byte(8'h5C, a); send_byte(8'h77, a); send_byte(8'hE4, a);
        bus_stop();
        bus_start();
        send_byte(8'h9A, a); send_byte(8'h31, a);
        bus_start();
        send_byte(8'h9B, a); chk("R9 read ack after rs", a, 1);
        recv_byte(1'b1, d); chk("R9 ptr kept over rs", d, 8'h77);
        recv_byte(1'b0, d); chk("R9 next byte", d, 8'hE4);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a; int unsigned oe_b, we_b;
        strap = 2'b11;
        oe_b = oe_cnt; we_b = we_cnt;
        bus_start();
        send_byte(8'h98, a); chk("R4 nack foreign addr", a, 0);
        chk("R4 not addressed", addressed_o, 0);
        send_byte(8'h40, a); send_byte(8'h99, a);
        bus_stop();
        chk("R4 no drive when unmatched", oe_cnt - oe_b, 0);
        chk("R4 no write when unmatched", we_cnt - we_b, 0);
        bus_start();
        send_byte(8'h9E, a); chk("R2 ack 0x9E strap 11", a, 1);
        send_byte(8'h60, a); send_byte(8'hAB, a);
        bus_stop();
        chk("R5 mem 0x60", mem[8'h60], 8'hAB);
    endtask

    task automatic t_bcast();
        logic a; logic [7:0] d; int unsigned oe_b;
        strap = 2'b11;
        bus_start();
        send_byte(8'h90, a); chk("R3 bcast write ack", a, 1);
        chk("R3 bcast flag", hit_bcast_o, 1);
        send_byte(8'h50, a); send_byte(8'h3C, a); chk("R6 bcast data ack", a, 1);
        bus_stop();
        chk("R3 bcast flag clear", hit_bcast_o, 0);
        chk("R3 bcast mem", mem[8'h50], 8'h3C);
        oe_b = oe_cnt;
        bus_start();
        send_byte(8'h91, a); chk("R4 bcast read nack", a, 0);
        recv_byte(1'b0, d);
        chk("R4 bcast read no drive", oe_cnt - oe_b, 0);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        strap = 2'b00;
        bus_start();
        send_byte(8'h98, a); send_byte(8'hFF, a);
        send_byte(8'h11, a); send_byte(8'h22, a);
        bus_stop();
        chk("R5 mem 0xFF", mem[8'hFF], 8'h11);
        chk("R5 wrap to 0x00", mem[8'h00], 8'h22);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_dev();
        t_read();
        t_rs_ptr();
        t_mismatch();
        t_bcast();
        t_wrap();
        chk("R10 oe edges with scl high", bad_edges, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule